// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory Entry

This block keeps the record of which nodes share one memory block. Normally the record is a short list of exact node pointers, each with its own valid bit. When a new sharer arrives and every pointer is in use, the record switches to a coarse vector that is packed into the same storage bits as the pointers. In that vector each bit stands for a fixed group of consecutive nodes.

Each command carries a node ID and takes one of three forms. An add command records the node as a sharer. A clear command empties the record. An owner command replaces the record with that single node. The block continuously expands the stored record into a full node mask, which lists every node that a write to the block must invalidate. It also reports a sharer count and which format is in use.

With the default configuration there are 16 nodes and 2 pointers. Each pointer is 4 bits wide, so the vector is 8 bits wide and each group holds 2 nodes. Group g covers nodes 2g and 2g+1.

Top module: `dsd_sharer_entry`

## Requirements
- R1: While `rst` is high, and on the clock edge that samples it high, the entry is set to pointer format with no valid pointers. After that edge, `inval_mask` is 0, `sharer_count` is 0 and `coarse_mode` is 0.
- R2: An add command (`cmd_op`=0) in pointer format is accepted when the node is not already recorded and a pointer is free. The node's bit appears in `inval_mask` and `sharer_count` rises by one, both from the edge that accepts the command.
- R3: In pointer format, an add command for a node that is already recorded leaves `inval_mask`, `sharer_count` and `coarse_mode` unchanged.
- R4: An add command for a new node while all pointers are valid sets `coarse_mode`. `inval_mask` then holds every node of the group of each previous pointer and of the new node, where group = node/2.
- R5: In coarse format, an add command sets the group bit of the node, so both nodes of its pair appear in `inval_mask`. A node whose group is already set leaves the entry unchanged. Coarse format stays in force until a clear or owner command.
- R6: `sharer_count` equals the number of valid pointers in pointer format. In coarse format it equals 2 times the number of set group bits.
- R7: A clear command (`cmd_op`=1) in either format returns the entry to pointer format with no sharers, so `inval_mask`=0 and `sharer_count`=0.
- R8: An owner command (`cmd_op`=2) in either format leaves exactly the given node in `inval_mask`, with `sharer_count`=1 and `coarse_mode`=0.
- R9: When `cmd_valid` is low, or when `cmd_op`=3, the entry does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 add, 1 clear, 2 owner, 3 no operation |
| cmd_node | input | $clog2(NODES) | Node ID carried by the command |
| inval_mask | output | NODES | Expanded set of nodes to invalidate |
| sharer_count | output | $clog2(NODES+1) | Valid pointers, or nodes implied by the vector |
| coarse_mode | output | 1 | 1 when the record is in coarse-vector format |

## Verification
A command registered on a rising edge is reflected in all three outputs on that same edge, because the mask and the count are decoded combinationally from the stored record. The bench drives each command on a falling edge and holds it for one clock. It compares the outputs on the next falling edge, half a cycle after the capturing edge, against a model of the pointer list and the pair groups. Every ordered triple of nodes is swept, followed by a coarse-format add, an owner command and an idle cycle, so duplicate, overflow and same-group cases all occur.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_CLEAR = 2'd1,
        OP_OWNER = 2'd2,
        OP_NONE  = 2'd3
    } dir_op_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int group_of(input int node, input int grp);
        return node / grp;
    endfunction

endpackage

// File: rtl/dsd_match.sv
module dsd_match #(
    parameter int PTRS   = 2,
    parameter int ID_W   = 4,
    parameter int SLOT_W = 1
) (
    input  logic [PTRS-1:0]      vld,
    input  logic [PTRS*ID_W-1:0] body,
    input  logic [ID_W-1:0]      node,
    output logic                 hit,
    output logic                 full,
    output logic [SLOT_W-1:0]    free_idx
);
    logic [PTRS-1:0] slot_hit;

    for (genvar k = 0; k < PTRS; k++) begin : g_slot
        assign slot_hit[k] = vld[k] && (body[k*ID_W +: ID_W] == node);
    end

    assign hit  = |slot_hit;
    assign full = &vld;

    always_comb begin
        free_idx = '0;
        for (int k = PTRS - 1; k >= 0; k--) begin
            if (!vld[k]) free_idx = SLOT_W'(k);
        end
    end
endmodule

// File: rtl/dsd_next.sv
module dsd_next
    import dsd_pkg::*;
#(
    parameter int PTRS   = 2,
    parameter int ID_W   = 4,
    parameter int SLOT_W = 1,
    parameter int GRP    = 2,
    parameter int GI_W   = 3
) (
    input  logic                 ovf,
    input  logic [PTRS-1:0]      vld,
    input  logic [PTRS*ID_W-1:0] body,
    input  logic                 cmd_valid,
    input  dir_op_e              op,
    input  logic [ID_W-1:0]      node,
    input  logic                 hit,
    input  logic                 full,
    input  logic [SLOT_W-1:0]    free_idx,
    output logic                 ovf_d,
    output logic [PTRS-1:0]      vld_d,
    output logic [PTRS*ID_W-1:0] body_d
);
    localparam int BODY_W = PTRS * ID_W;

    logic [BODY_W-1:0] conv_vec;

    // Coarse vector built from the current pointers plus the incoming node
    always_comb begin
        conv_vec = '0;
        for (int k = 0; k < PTRS; k++) begin
            conv_vec[GI_W'(group_of(int'(body[k*ID_W +: ID_W]), GRP))] = 1'b1;
        end
        conv_vec[GI_W'(group_of(int'(node), GRP))] = 1'b1;
    end

    always_comb begin
        ovf_d  = ovf;
        vld_d  = vld;
        body_d = body;
        if (cmd_valid) begin
            unique case (op)
                OP_CLEAR: begin
                    ovf_d  = 1'b0;
                    vld_d  = '0;
                    body_d = '0;
                end
                OP_OWNER: begin
                    ovf_d  = 1'b0;
                    vld_d  = PTRS'(1);
                    body_d = BODY_W'(node);
                end
                OP_ADD: begin
                    if (ovf) begin
                        body_d[GI_W'(group_of(int'(node), GRP))] = 1'b1;
                    end else if (hit) begin
                        body_d = body;
                    end else if (!full) begin
                        vld_d[free_idx]                = 1'b1;
                        body_d[free_idx*ID_W +: ID_W]  = node;
                    end else begin
                        ovf_d  = 1'b1;
                        vld_d  = '0;
                        body_d = conv_vec;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dsd_expand.sv
module dsd_expand
    import dsd_pkg::*;
#(
    parameter int NODES = 16,
    parameter int PTRS  = 2,
    parameter int ID_W  = 4,
    parameter int GRP   = 2,
    parameter int GI_W  = 3,
    parameter int CNT_W = 5
) (
    input  logic                 ovf,
    input  logic [PTRS-1:0]      vld,
    input  logic [PTRS*ID_W-1:0] body,
    output logic [NODES-1:0]     mask,
    output logic [CNT_W-1:0]     count
);
    logic [NODES-1:0] ptr_mask;
    logic [NODES-1:0] vec_mask;

    for (genvar n = 0; n < NODES; n++) begin : g_node
        always_comb begin
            ptr_mask[n] = 1'b0;
            for (int k = 0; k < PTRS; k++) begin
                if (vld[k] && body[k*ID_W +: ID_W] == ID_W'(n)) ptr_mask[n] = 1'b1;
            end
        end
        assign vec_mask[n] = body[GI_W'(group_of(n, GRP))];
    end

    assign mask = ovf ? vec_mask : ptr_mask;

    always_comb begin
        count = '0;
        if (ovf) begin
            for (int n = 0; n < NODES; n++) count = count + CNT_W'(vec_mask[n]);
        end else begin
            for (int k = 0; k < PTRS; k++) count = count + CNT_W'(vld[k]);
        end
    end
endmodule

// File: rtl/dsd_sharer_entry.sv
module dsd_sharer_entry
    import dsd_pkg::*;
#(
    parameter int NODES = 16,
    parameter int PTRS  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [$clog2(NODES)-1:0]   cmd_node,
    output logic [NODES-1:0]           inval_mask,
    output logic [$clog2(NODES+1)-1:0] sharer_count,
    output logic                       coarse_mode
);
    localparam int ID_W   = $clog2(NODES);
    localparam int BODY_W = PTRS * ID_W;
    localparam int GRP    = ceil_div(NODES, BODY_W);
    localparam int GI_W   = (BODY_W > 1) ? $clog2(BODY_W) : 1;
    localparam int SLOT_W = (PTRS > 1) ? $clog2(PTRS) : 1;
    localparam int CNT_W  = $clog2(NODES + 1);

    logic              ovf_q, ovf_d;
    logic [PTRS-1:0]   vld_q, vld_d;
    logic [BODY_W-1:0] body_q, body_d;
    logic              hit, full;
    logic [SLOT_W-1:0] free_idx;
    dir_op_e           op;

    assign op = dir_op_e'(cmd_op);

    dsd_match #(.PTRS(PTRS), .ID_W(ID_W), .SLOT_W(SLOT_W)) u_match (
        .vld(vld_q), .body(body_q), .node(cmd_node),
        .hit(hit), .full(full), .free_idx(free_idx)
    );

    dsd_next #(.PTRS(PTRS), .ID_W(ID_W), .SLOT_W(SLOT_W), .GRP(GRP), .GI_W(GI_W)) u_next (
        .ovf(ovf_q), .vld(vld_q), .body(body_q),
        .cmd_valid(cmd_valid), .op(op), .node(cmd_node),
        .hit(hit), .full(full), .free_idx(free_idx),
        .ovf_d(ovf_d), .vld_d(vld_d), .body_d(body_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            vld_q  <= '0;
            body_q <= '0;
        end else begin
            ovf_q  <= ovf_d;
            vld_q  <= vld_d;
            body_q <= body_d;
        end
    end

    dsd_expand #(.NODES(NODES), .PTRS(PTRS), .ID_W(ID_W), .GRP(GRP), .GI_W(GI_W),
                 .CNT_W(CNT_W)) u_expand (
        .ovf(ovf_q), .vld(vld_q), .body(body_q),
        .mask(inval_mask), .count(sharer_count)
    );

    assign coarse_mode = ovf_q;
endmodule

// File: rtl/dsd_sharer_entry_chk.sv
module dsd_sharer_entry_chk
    import dsd_pkg::*;
#(
    parameter int NODES = 16,
    parameter int PTRS  = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cmd_valid,
    input logic [1:0]                 cmd_op,
    input logic [$clog2(NODES)-1:0]   cmd_node,
    input logic [NODES-1:0]           inval_mask,
    input logic [$clog2(NODES+1)-1:0] sharer_count,
    input logic                       coarse_mode
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (inval_mask == '0 && sharer_count == '0 && !coarse_mode));

    a_r2_added_node_visible: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ADD) |=> inval_mask[$past(cmd_node)]);

    a_r3_add_never_removes: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_ADD) |=> ((inval_mask & $past(inval_mask)) == $past(inval_mask)));

    a_r5_coarse_sticky: assert property (@(posedge clk) disable iff (rst)
        (coarse_mode && !(cmd_valid && (cmd_op == OP_CLEAR || cmd_op == OP_OWNER))) |=> coarse_mode);

    a_r6_pointer_count_bound: assert property (@(posedge clk) disable iff (rst)
        !coarse_mode |-> (sharer_count <= PTRS));

    a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_CLEAR) |=> (inval_mask == '0 && !coarse_mode));

    a_r8_owner_single: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_OWNER) |=> ($countones(inval_mask) == 1 && sharer_count == 1 && !coarse_mode));

    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op == OP_NONE) |=> ($stable(inval_mask) && $stable(coarse_mode) && $stable(sharer_count)));
endmodule

bind dsd_sharer_entry dsd_sharer_entry_chk #(.NODES(NODES), .PTRS(PTRS)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
    .inval_mask(inval_mask), .sharer_count(sharer_count), .coarse_mode(coarse_mode)
);

// File: tb/tb_dsd_sharer_entry.sv
module tb_dsd_sharer_entry;
    localparam int NODES = 16;
    localparam int PTRS  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd3;
    logic [3:0]  cmd_node = '0;
    logic [15:0] inval_mask;
    logic [4:0]  sharer_count;
    logic        coarse_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model
    bit          m_coarse;
    int          m_np;
    int          m_p[PTRS];
    logic [15:0] m_vec;

    always #2 clk = ~clk;

    dsd_sharer_entry #(.NODES(NODES), .PTRS(PTRS)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
        .inval_mask(inval_mask), .sharer_count(sharer_count), .coarse_mode(coarse_mode)
    );

    function automatic logic [15:0] pair_bits(input int n);
        int g;
        g = n / 2;
        return 16'(3) << (2 * g);
    endfunction

    function automatic logic [15:0] exp_mask();
        logic [15:0] m;
        if (m_coarse) return m_vec;
        m = '0;
        for (int k = 0; k < m_np; k++) m[m_p[k]] = 1'b1;
        return m;
    endfunction

    function automatic int exp_count();
        if (m_coarse) return $countones(m_vec);
        return m_np;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, {15'd0, coarse_mode, 11'd0, sharer_count, inval_mask} >> 0,
              {15'd0, m_coarse, 11'd0, 5'(exp_count()), exp_mask()});
    endtask

    task automatic issue(input logic [1:0] op, input int n);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_node  = 4'(n);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'd3;
    endtask

    task automatic model_clear();
        m_coarse = 0; m_np = 0; m_vec = '0;
    endtask

    // returns tag of behaviour exercised
    task automatic model_add(input int n, output string tag);
        bit dup;
        dup = 0;
        for (int k = 0; k < m_np; k++) if (m_p[k] == n) dup = 1;
        if (m_coarse) begin
            tag = "R5";
            m_vec = m_vec | pair_bits(n);
        end else if (dup) begin
            tag = "R3";
        end else if (m_np < PTRS) begin
            tag = "R2";
            m_p[m_np] = n;
            m_np++;
        end else begin
            tag = "R4";
            m_coarse = 1;
            m_vec = pair_bits(n);
            for (int k = 0; k < PTRS; k++) m_vec = m_vec | pair_bits(m_p[k]);
        end
    endtask

    task automatic do_add(input int n);
        string tag;
        model_add(n, tag);
        issue(2'd0, n);
        check_all(tag);
        if (m_coarse) check("R6 count", 32'(sharer_count), 32'(2 * $countones(m_vec) / 2 * 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {15'd0, coarse_mode, 11'd0, sharer_count, inval_mask}, 32'd0);
        rst = 1'b0;
        model_clear();

        // R9: op 3 with strobe high is ignored
        do_add(5);
        issue(2'd3, 9);
        check_all("R9 nop op");

        for (int a = 0; a < NODES; a++) begin
            for (int b = 0; b < NODES; b++) begin
                for (int c = 0; c < NODES; c++) begin
                    model_clear();
                    issue(2'd1, a);
                    check_all("R7 clear");
                    do_add(a);
                    do_add(b);
                    do_add(c);
                    do_add((a + 3 * b + 7 * c) % NODES);
                    if (m_coarse) check("R6 pairs", 32'(sharer_count), 32'(2 * $countones(m_vec >> 0) / 2));
                    m_coarse = 0; m_np = 1; m_p[0] = c;
                    issue(2'd2, c);
                    check_all("R8 owner");
                    @(negedge clk);
                    check_all("R9 idle");
                end
            end
        end

        // coarse format then owner then clear
        model_clear();
        issue(2'd1, 0);
        do_add(0); do_add(4); do_add(15); do_add(1);
        check("R4 coarse flag", 32'(coarse_mode), 32'd1);
        m_coarse = 0; m_np = 1; m_p[0] = 11;
        issue(2'd2, 11);
        check_all("R8 owner from coarse");
        model_clear();
        issue(2'd1, 3);
        check_all("R7 clear after owner");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule